// File: doc/BRIEF.md
# DDR2 Power-Down Entry/Exit Sequencer

This block belongs to a DDR2 memory controller and owns the clock-enable pin (CKE). It watches every command the controller issues. For each command it keeps the time that must pass before the clock may be stopped: the read burst after a read, the write latency, burst and write recovery after a write, and the row precharge time after a precharge. A level-sensitive power-down request drops CKE only after that time has run out. The request also has to stay high until then, and no command may be issued in the same cycle.

The block keeps an open/closed bit for each bank. If any row is still open when CKE falls, the part is in active power-down. Its exit delay is one of two programmable values, chosen by the fast/slow exit bit held in the mode register. If all banks are closed, the part is in precharge power-down, and its exit delay is a third value. A wake request raises CKE at once. The command-allowed flag then stays low until the selected exit delay has run out.

All latency and timing settings are 4-bit cycle counts. A timing value of zero is treated as one cycle. Latency values may be zero.

Top module: `ddr2_pd_sequencer`

## Requirements
- R1: After reset, and whenever reset is asserted, cke_o=1, cmd_ok_o=1 and pd_state_o=0 (idle).
- R2: A command is taken only when cmd_valid_i=1 and cmd_ok_o=1. Any other command is ignored and changes neither the bank state nor the timing. cmd_kind_i encoding: 0 no-op, 1 activate, 2 read, 3 read with auto-precharge, 4 write, 5 write with auto-precharge, 6 precharge one bank, 7 precharge all.
- R3: After a read (kind 2 or 3) taken at clock edge P, CKE falls no earlier than edge P+N+1, where N = AL + CL + BL/2 (cfg_al_i + cfg_cl_i + cfg_bhalf_i).
- R4: After a write (kind 4), N = WL + BL/2 + tWR. After a write with auto-precharge (kind 5), N = WL + BL/2 + tWR + tRP.
- R5: After a precharge (kind 6 or 7), N = tRP.
- R6: A value of zero in cfg_twr_i, cfg_trp_i, cfg_xfast_i, cfg_xslow_i or cfg_xpre_i counts as one cycle.
- R7: When several commands overlap, the longest remaining wait governs entry.
- R8: CKE falls at the first clock edge where the idle state holds, pd_req_i=1, the wait has run out, and no command is taken in that cycle. If pd_req_i drops first, CKE stays high.
- R9: Activate opens its bank. Kinds 3, 5 and 6 close the addressed bank, and kind 7 closes all banks. At entry, pd_state_o becomes 1 (active power-down) if any bank is open and 2 (precharge power-down) otherwise. The state then holds until a wake request.
- R10: wake_req_i in state 1 or 2 raises CKE at the next edge W and sets pd_state_o=3. cmd_ok_o rises exactly D edges after W. D is cfg_xfast_i (cfg_slow_exit_i=0) or cfg_xslow_i (cfg_slow_exit_i=1) for active power-down, and cfg_xpre_i for precharge power-down.
- R11: cmd_ok_o is 0 whenever CKE is low or an exit is in progress. wake_req_i has no effect in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command issued this cycle |
| cmd_kind_i | input | 3 | Command type (see R2) |
| cmd_bank_i | input | BANK_W | Bank addressed by the command |
| pd_req_i | input | 1 | Level request to enter power-down |
| wake_req_i | input | 1 | Request to leave power-down |
| cfg_al_i | input | 4 | Additive latency, cycles |
| cfg_cl_i | input | 4 | CAS latency, cycles |
| cfg_wl_i | input | 4 | Write latency, cycles |
| cfg_bhalf_i | input | 4 | Burst length divided by two |
| cfg_twr_i | input | 4 | Write recovery, cycles |
| cfg_trp_i | input | 4 | Row precharge time, cycles |
| cfg_xfast_i | input | 4 | Active power-down fast exit delay |
| cfg_xslow_i | input | 4 | Active power-down slow exit delay |
| cfg_xpre_i | input | 4 | Precharge power-down exit delay |
| cfg_slow_exit_i | input | 1 | Mode-register exit type: 1 selects slow exit |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_ok_o | output | 1 | Controller may issue a command |
| pd_state_o | output | 2 | 0 idle, 1 active power-down, 2 precharge power-down, 3 exiting |

## Verification
The assertions check properties that must hold on every cycle. CKE is low exactly in the two power-down states. The command-allowed flag is low whenever CKE is low. CKE never falls unless the wait counter was empty and no command was taken in the previous cycle. Each rising CKE begins an exit with commands still blocked. The exact number of cycles each command type imposes can only be shown by the bench's scenarios. The same holds for the max-merge of overlapping waits, the choice of exit delay, and the zero-as-one rule. The bench also shows that commands issued during power-down leave the bank state untouched.

// File: rtl/ddr2_pd_pkg.sv
package ddr2_pd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_RDA  = 3'd3,
        CMD_WR   = 3'd4,
        CMD_WRA  = 3'd5,
        CMD_PRE  = 3'd6,
        CMD_PREA = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PD_ACT = 2'd1,
        ST_PD_PRE = 2'd2,
        ST_EXIT   = 2'd3
    } pd_state_e;

    typedef struct packed {
        pd_state_e st;
        logic      cke;
        logic      cmd_ok;
    } seq_t;

endpackage

// File: rtl/ddr2_pd_bank_track.sv
module ddr2_pd_bank_track
    import ddr2_pd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fire_i,
    input  cmd_e              kind_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              any_open_o
);

    logic [NUM_BANKS-1:0] open_d, open_q;

    // One set/clear cell per bank; precharge-all clears every bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit, set_b, clr_b;
        assign hit   = (bank_i == BANK_W'(b));
        assign set_b = fire_i && hit && (kind_i == CMD_ACT);
        assign clr_b = fire_i && ((kind_i == CMD_PREA) ||
                       (hit && ((kind_i == CMD_PRE) || (kind_i == CMD_RDA) ||
                                (kind_i == CMD_WRA))));
        assign open_d[b] = set_b ? 1'b1 : (clr_b ? 1'b0 : open_q[b]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) open_q <= '0;
        else         open_q <= open_d;
    end

    assign any_open_o = |open_q;

endmodule

// File: rtl/ddr2_pd_guard.sv
module ddr2_pd_guard
    import ddr2_pd_pkg::*;
#(
    parameter int TW = 4,
    parameter int GW = TW + 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fire_i,
    input  cmd_e          kind_i,
    input  logic [TW-1:0] al_i,
    input  logic [TW-1:0] cl_i,
    input  logic [TW-1:0] wl_i,
    input  logic [TW-1:0] bhalf_i,
    input  logic [TW-1:0] twr_i,
    input  logic [TW-1:0] trp_i,
    output logic          idle_o
);

    logic [TW-1:0] twr_eff, trp_eff;
    logic [GW-1:0] rd_len, wr_len, wra_len, pre_len, need, dec;
    logic [GW-1:0] cnt_d, cnt_q;

    assign twr_eff = (twr_i == '0) ? TW'(1) : twr_i;
    assign trp_eff = (trp_i == '0) ? TW'(1) : trp_i;

    assign rd_len  = GW'(al_i) + GW'(cl_i) + GW'(bhalf_i);
    assign wr_len  = GW'(wl_i) + GW'(bhalf_i) + GW'(twr_eff);
    assign wra_len = wr_len + GW'(trp_eff);
    assign pre_len = GW'(trp_eff);

    always_comb begin
        unique case (kind_i)
            CMD_RD, CMD_RDA:   need = rd_len;
            CMD_WR:            need = wr_len;
            CMD_WRA:           need = wra_len;
            CMD_PRE, CMD_PREA: need = pre_len;
            default:           need = '0;
        endcase
        dec   = (cnt_q == '0) ? '0 : cnt_q - GW'(1);
        cnt_d = (fire_i && (need > dec)) ? need : dec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign idle_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2_pd_exit_timer.sv
module ddr2_pd_exit_timer #(
    parameter int TW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [TW-1:0] delay_i,
    output logic          last_o
);

    logic [TW-1:0] delay_eff, cnt_d, cnt_q;

    assign delay_eff = (delay_i == '0) ? TW'(1) : delay_i;

    always_comb begin
        if (start_i)             cnt_d = delay_eff;
        else if (cnt_q > TW'(1)) cnt_d = cnt_q - TW'(1);
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q <= TW'(1));

endmodule

// File: rtl/ddr2_pd_sequencer.sv
module ddr2_pd_sequencer
    import ddr2_pd_pkg::*;
#(
    parameter int  NUM_BANKS = 4,
    parameter int  TW        = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int GW        = TW + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_kind_i,
    input  logic [BANK_W-1:0] cmd_bank_i,
    input  logic              pd_req_i,
    input  logic              wake_req_i,
    input  logic [TW-1:0]     cfg_al_i,
    input  logic [TW-1:0]     cfg_cl_i,
    input  logic [TW-1:0]     cfg_wl_i,
    input  logic [TW-1:0]     cfg_bhalf_i,
    input  logic [TW-1:0]     cfg_twr_i,
    input  logic [TW-1:0]     cfg_trp_i,
    input  logic [TW-1:0]     cfg_xfast_i,
    input  logic [TW-1:0]     cfg_xslow_i,
    input  logic [TW-1:0]     cfg_xpre_i,
    input  logic              cfg_slow_exit_i,
    output logic              cke_o,
    output logic              cmd_ok_o,
    output logic [1:0]        pd_state_o
);

    seq_t          seq_d, seq_q;
    cmd_e          kind;
    logic          fire, any_open, guard_idle, exit_last, exit_start;
    logic [TW-1:0] exit_delay;

    assign kind = cmd_e'(cmd_kind_i);
    assign fire = cmd_valid_i && seq_q.cmd_ok;

    ddr2_pd_bank_track #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fire_i     (fire),
        .kind_i     (kind),
        .bank_i     (cmd_bank_i),
        .any_open_o (any_open)
    );

    ddr2_pd_guard #(.TW(TW), .GW(GW)) u_guard (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fire_i  (fire),
        .kind_i  (kind),
        .al_i    (cfg_al_i),
        .cl_i    (cfg_cl_i),
        .wl_i    (cfg_wl_i),
        .bhalf_i (cfg_bhalf_i),
        .twr_i   (cfg_twr_i),
        .trp_i   (cfg_trp_i),
        .idle_o  (guard_idle)
    );

    // Exit delay depends on which power-down flavour is being left.
    always_comb begin
        if (seq_q.st == ST_PD_ACT)
            exit_delay = cfg_slow_exit_i ? cfg_xslow_i : cfg_xfast_i;
        else
            exit_delay = cfg_xpre_i;
    end

    ddr2_pd_exit_timer #(.TW(TW)) u_exit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (exit_start),
        .delay_i (exit_delay),
        .last_o  (exit_last)
    );

    always_comb begin
        seq_d      = seq_q;
        exit_start = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (!fire && pd_req_i && guard_idle) begin
                    seq_d.cke    = 1'b0;
                    seq_d.cmd_ok = 1'b0;
                    seq_d.st     = any_open ? ST_PD_ACT : ST_PD_PRE;
                end
            end
            ST_PD_ACT, ST_PD_PRE: begin
                if (wake_req_i) begin
                    seq_d.cke  = 1'b1;
                    seq_d.st   = ST_EXIT;
                    exit_start = 1'b1;
                end
            end
            ST_EXIT: begin
                if (exit_last) begin
                    seq_d.st     = ST_IDLE;
                    seq_d.cmd_ok = 1'b1;
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.st     <= ST_IDLE;
            seq_q.cke    <= 1'b1;
            seq_q.cmd_ok <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cke_o      = seq_q.cke;
    assign cmd_ok_o   = seq_q.cmd_ok;
    assign pd_state_o = seq_q.st;

endmodule

// File: rtl/ddr2_pd_sequencer_chk.sv
module ddr2_pd_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       wake_req,
    input logic       cke,
    input logic       cmd_ok,
    input logic [1:0] pd_state,
    input logic       guard_idle
);

    // R9: CKE is low exactly while in one of the power-down states
    a_r9_cke_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        (((pd_state == 2'd1) || (pd_state == 2'd2)) == !cke));

    // R8: CKE falls only after the wait ran out
    a_r8_entry_after_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(guard_idle));

    // R8: no command was taken in the cycle CKE was dropped
    a_r8_entry_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!(cmd_valid && cmd_ok)));

    // R11: commands blocked while CKE is low
    a_r11_ok_low_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cmd_ok);

    // R10: every CKE rise starts an exit with commands still blocked
    a_r10_exit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!cmd_ok && (pd_state == 2'd3)));

    // R11: idle never jumps straight to exiting
    a_r11_idle_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_state == 2'd0) |=> (pd_state != 2'd3));

    // R9: active power-down holds without a wake request
    a_r9_pd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((pd_state == 2'd1) && !wake_req) |=> (pd_state == 2'd1));

endmodule

bind ddr2_pd_sequencer ddr2_pd_sequencer_chk u_chk (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .cmd_valid  (cmd_valid_i),
    .wake_req   (wake_req_i),
    .cke        (cke_o),
    .cmd_ok     (cmd_ok_o),
    .pd_state   (pd_state_o),
    .guard_idle (guard_idle)
);

// File: tb/ddr2_pd_sequencer_tb.sv
`timescale 1ns/1ps
module ddr2_pd_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_kind = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       pd_req = 1'b0, wake_req = 1'b0;
    logic [3:0] al = 0, cl = 0, wl = 0, bh = 0, twr = 0, trp = 0, xf = 0, xs = 0, xp = 0;
    logic       slow = 1'b0;
    logic       cke, cmd_ok;
    logic [1:0] pd_state;
    int         tests = 0, fails = 0, n = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    ddr2_pd_sequencer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
        .cmd_bank_i(cmd_bank), .pd_req_i(pd_req), .wake_req_i(wake_req),
        .cfg_al_i(al), .cfg_cl_i(cl), .cfg_wl_i(wl), .cfg_bhalf_i(bh),
        .cfg_twr_i(twr), .cfg_trp_i(trp), .cfg_xfast_i(xf), .cfg_xslow_i(xs),
        .cfg_xpre_i(xp), .cfg_slow_exit_i(slow),
        .cke_o(cke), .cmd_ok_o(cmd_ok), .pd_state_o(pd_state)
    );

    typedef struct packed {
        logic [2:0] kind;
        logic       open_first;
        logic [3:0] al, cl, wl, bh, twr, trp, xf, xs, xp;
        logic       slow;
        logic [6:0] exp_entry;
        logic [1:0] exp_state;
        logic [4:0] exp_exit;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 1'b1, 4'd1, 4'd3, 4'd2, 4'd2, 4'd2, 4'd3, 4'd2, 4'd6, 4'd3, 1'b0, 7'd7,  2'd1, 5'd2},
        '{3'd2, 1'b1, 4'd1, 4'd3, 4'd2, 4'd2, 4'd2, 4'd3, 4'd2, 4'd6, 4'd3, 1'b1, 7'd7,  2'd1, 5'd6},
        '{3'd3, 1'b1, 4'd0, 4'd4, 4'd2, 4'd4, 4'd2, 4'd3, 4'd2, 4'd6, 4'd5, 1'b0, 7'd9,  2'd2, 5'd5},
        '{3'd4, 1'b1, 4'd1, 4'd3, 4'd2, 4'd2, 4'd2, 4'd3, 4'd3, 4'd6, 4'd3, 1'b0, 7'd7,  2'd1, 5'd3},
        '{3'd5, 1'b1, 4'd0, 4'd0, 4'd3, 4'd4, 4'd5, 4'd4, 4'd2, 4'd2, 4'd0, 1'b0, 7'd17, 2'd2, 5'd1},
        '{3'd6, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd2, 4'd2, 4'd7, 1'b0, 7'd2,  2'd2, 5'd7},
        '{3'd6, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd9, 4'd2, 4'd2, 4'd2, 1'b1, 7'd10, 2'd2, 5'd2},
        '{3'd4, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd4, 4'd0, 4'd4, 1'b1, 7'd2,  2'd1, 5'd1},
        '{3'd2, 1'b0, 4'd2, 4'd5, 4'd0, 4'd8, 4'd0, 4'd0, 4'd2, 4'd2, 4'd4, 1'b0, 7'd16, 2'd2, 5'd4},
        '{3'd1, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd15,4'd1, 4'd1, 1'b0, 7'd1,  2'd1, 5'd15}
    };

    function automatic string entry_tag(input logic [2:0] k);
        case (k)
            3'd2, 3'd3: return "R3 read entry";
            3'd4, 3'd5: return "R4 write entry";
            3'd6, 3'd7: return "R5 precharge entry";
            default:    return "R9 activate entry";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; leaves at the falling edge after the command edge.
    task automatic issue(input logic [2:0] k, input logic [1:0] b);
        cmd_valid = 1'b1; cmd_kind = k; cmd_bank = b;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 3'd0;
    endtask

    task automatic wait_cke_low(output int cnt);
        cnt = 0;
        while (cke && cnt < 200) begin @(posedge clk); cnt++; @(negedge clk); end
    endtask

    task automatic wake_and_count(output int cnt);
        pd_req = 1'b0; wake_req = 1'b1;
        @(posedge clk); @(negedge clk);
        wake_req = 1'b0;
        cnt = 0;
        while (!cmd_ok && cnt < 200) begin @(posedge clk); cnt++; @(negedge clk); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cke === 1'b1 && cmd_ok === 1'b0 + 1'b1 && pd_state === 2'd0, "R1 state in reset", pd_state, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cke === 1'b1 && cmd_ok === 1'b1 && pd_state === 2'd0, "R1 state after reset", {cke, cmd_ok, pd_state}, 12);

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            al = VECS[i].al; cl = VECS[i].cl; wl = VECS[i].wl; bh = VECS[i].bh;
            twr = VECS[i].twr; trp = VECS[i].trp; xf = VECS[i].xf; xs = VECS[i].xs;
            xp = VECS[i].xp; slow = VECS[i].slow;
            issue(3'd7, 2'd0);
            if (VECS[i].open_first) issue(3'd1, 2'd2);
            repeat (20) @(negedge clk);
            pd_req = 1'b1;
            issue(VECS[i].kind, 2'd2);
            wait_cke_low(n);
            check(n == int'(VECS[i].exp_entry), entry_tag(VECS[i].kind), n, VECS[i].exp_entry);
            check(pd_state == VECS[i].exp_state, "R9 power-down flavour", pd_state, VECS[i].exp_state);
            check(cmd_ok == 1'b0, "R11 commands blocked in power-down", cmd_ok, 0);
            pd_req = 1'b0; wake_req = 1'b1;
            @(posedge clk); @(negedge clk);
            wake_req = 1'b0;
            check(cke == 1'b1 && pd_state == 2'd3, "R10 exit state after wake", pd_state, 3);
            n = 0;
            while (!cmd_ok && n < 200) begin @(posedge clk); n++; @(negedge clk); end
            check(n == int'(VECS[i].exp_exit), "R10 exit delay", n, VECS[i].exp_exit);
        end

        // R11: wake in idle has no effect
        wake_req = 1'b1;
        @(posedge clk); @(negedge clk);
        wake_req = 1'b0;
        @(negedge clk);
        check(cke == 1'b1 && cmd_ok == 1'b1 && pd_state == 2'd0, "R11 wake ignored in idle", pd_state, 0);

        // R6: zero timing treated as one
        al = 0; cl = 0; wl = 0; bh = 0; twr = 0; trp = 0; xf = 0; xs = 0; xp = 0; slow = 0;
        issue(3'd7, 2'd0);
        repeat (20) @(negedge clk);
        pd_req = 1'b1;
        issue(3'd6, 2'd1);
        wait_cke_low(n);
        check(n == 2, "R6 zero tRP counts as one", n, 2);
        wake_and_count(n);
        check(n == 1, "R6 zero exit delay counts as one", n, 1);

        // R8: request dropped before wait runs out
        trp = 4'd10;
        pd_req = 1'b1;
        issue(3'd6, 2'd1);
        repeat (3) @(negedge clk);
        pd_req = 1'b0;
        repeat (15) @(negedge clk);
        check(cke == 1'b1 && pd_state == 2'd0, "R8 no entry without held request", cke, 1);
        pd_req = 1'b1;
        wait_cke_low(n);
        check(n == 1, "R8 entry one edge after request with wait expired", n, 1);
        wake_and_count(n);

        // R7: overlapping waits, longest governs
        al = 0; cl = 2; wl = 5; bh = 4; twr = 9; trp = 1; xf = 2; xs = 2; xp = 2;
        issue(3'd7, 2'd0);
        issue(3'd1, 2'd1);
        repeat (20) @(negedge clk);
        issue(3'd4, 2'd1);
        pd_req = 1'b1;
        issue(3'd2, 2'd1);
        wait_cke_low(n);
        check(n == 18, "R7 longest pending wait governs", n, 18);
        check(pd_state == 2'd1, "R9 open bank gives active power-down", pd_state, 1);

        // R2: command during power-down ignored
        pd_req = 1'b0;
        issue(3'd7, 2'd0);
        check(cke == 1'b0 && pd_state == 2'd1, "R2 command in power-down ignored", pd_state, 1);
        wake_and_count(n);
        pd_req = 1'b1;
        wait_cke_low(n);
        check(n == 1, "R2 ignored command left no wait", n, 1);
        check(pd_state == 2'd1, "R2 ignored precharge left bank open", pd_state, 1);

        // R1: reset during power-down
        rst_n = 1'b0;
        #1;
        check(cke == 1'b1 && cmd_ok == 1'b1 && pd_state == 2'd0, "R1 reset from power-down", pd_state, 0);
        pd_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cke == 1'b1 && cmd_ok == 1'b1, "R1 idle after reset release", cke, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule